// File: doc/BRIEF.md
# Decode-Stage Read-After-Write Interlock

This unit sits beside the decode stage of an in-order five-stage pipeline that has no operand forwarding. Each cycle it compares the source register numbers of the instruction being decoded with the destination register numbers of the instructions still in flight in execute, memory and write-back. When an operand would be read before its producer has written it back, the unit freezes the program counter and the fetch/decode register. It also tells the execute stage to take an empty slot instead of the held instruction.

The register file is written early in a cycle and read late in the same cycle. A producer that has reached write-back therefore never holds up decode, and only execute and memory can raise the stall. A destination of register 0 and a source that the instruction does not use never count toward a match. A registered counter reports how many consecutive cycles the present stall has lasted. The pipeline control uses it for stall accounting.

Top module: `rawlock_unit`

## Requirements
- R1: When the execute-stage descriptor is valid, has write enable set and a nonzero destination equal to a used source of the decoding instruction, `stall_fetch` is 1 in the same cycle.
- R2: The same match against the memory-stage descriptor also drives `stall_fetch` to 1 in the same cycle.
- R3: A match against the write-back descriptor alone leaves `stall_fetch` at 0, because the write there is visible to the decode read of that cycle.
- R4: An execute or memory descriptor whose valid bit or write-enable bit is 0 never causes a stall, even when its destination matches.
- R5: A destination register number of 0 never causes a stall.
- R6: A source whose use flag is 0 is left out of every comparison.
- R7: `bubble_ex` equals `stall_fetch` in every cycle.
- R8: `hold_count` is 0 during reset. After each clock edge it is 0 if `stall_fetch` was 0 before that edge. Otherwise it is the previous value plus one, saturating at all ones (7 with the default width of 3).
- R9: In a running pipeline, an instruction that reads the result of the instruction directly ahead of it is stalled for exactly 2 cycles. One that reads the result of the instruction two ahead is stalled for exactly 1 cycle.
- R10: The second source (`id_rs_b` with `id_rs_b_use`) is compared by the same rules as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs_a | input | REG_AW | First source register of the decoding instruction |
| id_rs_a_use | input | 1 | First source is read by the instruction |
| id_rs_b | input | REG_AW | Second source register of the decoding instruction |
| id_rs_b_use | input | 1 | Second source is read by the instruction |
| ex_vld | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | REG_AW | Execute-stage destination register |
| mem_vld | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_AW | Memory-stage destination register |
| wb_vld | input | 1 | Write-back stage holds a real instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_rd | input | REG_AW | Write-back destination register |
| stall_fetch | output | 1 | Freeze program counter and fetch/decode register |
| bubble_ex | output | 1 | Load an invalid slot into the execute stage |
| hold_count | output | CNT_W | Consecutive stall cycles so far, saturating |

## Verification
The bench targets matches that must not stall: a producer in write-back, an invalid or non-writing producer, destination 0, and an unused source that happens to match. A design that compared too eagerly would freeze decode there and lose throughput. It also drives real dependencies on either source against execute and memory, where a design that missed one would let the instruction read a stale register. A small pipeline model confirms the two-cycle and one-cycle stall lengths, which catches any off-by-one in which stages are checked. A long stall exercises counter saturation, which a faulty counter would wrap back to zero.

// File: rtl/rawlock_pkg.sv
`timescale 1ns/1ps
package rawlock_pkg;

   // Ahead-of-decode stage order; used as the slice index of the flattened
   // destination bus, youngest producer at index 0.
   typedef enum int unsigned {
      AHEAD_EX  = 0,
      AHEAD_MEM = 1,
      AHEAD_WB  = 2
   } ahead_e;

   localparam int unsigned AHEAD_N = 3;
   localparam int unsigned SRC_N   = 2;

   // Stages whose match may hold decode. With split-cycle register file
   // access the write-back producer is already readable.
   function automatic logic [AHEAD_N-1:0] live_stages(input bit wb_same_cycle);
      logic [AHEAD_N-1:0] m;
      m = '1;
      if (wb_same_cycle) m[int'(AHEAD_WB)] = 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/rawlock_cmp.sv
`timescale 1ns/1ps
module rawlock_cmp #(
   parameter int unsigned AW        = 5,
   parameter bit          ZERO_SKIP = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic          src_use,
   input  logic [AW-1:0] dst,
   input  logic          dst_vld,
   input  logic          dst_wen,
   output logic          hit
);

   logic dst_real;

   generate
      if (ZERO_SKIP) begin : g_zero_fixed
         assign dst_real = |dst;
      end else begin : g_zero_plain
         assign dst_real = 1'b1;
      end
   endgenerate

   assign hit = src_use & dst_vld & dst_wen & dst_real & (src == dst);

endmodule

// File: rtl/rawlock_src.sv
`timescale 1ns/1ps
module rawlock_src #(
   parameter int unsigned        AW        = 5,
   parameter int unsigned        NSTG      = 3,
   parameter logic [NSTG-1:0]    LIVE_MASK = '1,
   parameter bit                 ZERO_SKIP = 1'b1
) (
   input  logic [AW-1:0]      src,
   input  logic               src_use,
   input  logic [NSTG*AW-1:0] dst_flat,
   input  logic [NSTG-1:0]    dst_vld,
   input  logic [NSTG-1:0]    dst_wen,
   output logic               hit
);

   logic [NSTG-1:0] stg_hit;

   generate
      for (genvar g = 0; g < NSTG; g++) begin : g_stage
         rawlock_cmp #(
            .AW        (AW),
            .ZERO_SKIP (ZERO_SKIP)
         ) u_cmp (
            .src     (src),
            .src_use (src_use),
            .dst     (dst_flat[g*AW +: AW]),
            .dst_vld (dst_vld[g]),
            .dst_wen (dst_wen[g]),
            .hit     (stg_hit[g])
         );
      end
   endgenerate

   assign hit = |(stg_hit & LIVE_MASK);

endmodule

// File: rtl/rawlock_holdcnt.sv
`timescale 1ns/1ps
module rawlock_holdcnt #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!stall) begin
         cnt <= '0;
      end else if (cnt != CNT_TOP) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rawlock_unit.sv
`timescale 1ns/1ps
module rawlock_unit
   import rawlock_pkg::*;
#(
   parameter int unsigned REG_AW         = 5,
   parameter int unsigned CNT_W          = 3,
   parameter bit          WB_SAME_CYCLE  = 1'b1,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs_a,
   input  logic              id_rs_a_use,
   input  logic [REG_AW-1:0] id_rs_b,
   input  logic              id_rs_b_use,
   input  logic              ex_vld,
   input  logic              ex_wen,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              mem_vld,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              wb_vld,
   input  logic              wb_wen,
   input  logic [REG_AW-1:0] wb_rd,
   output logic              stall_fetch,
   output logic              bubble_ex,
   output logic [CNT_W-1:0]  hold_count
);

   localparam int unsigned       NSTG      = AHEAD_N;
   localparam int unsigned       NSRC      = SRC_N;
   localparam logic [NSTG-1:0]   LIVE_MASK = live_stages(WB_SAME_CYCLE);

   generate
      if (REG_AW < 1 || REG_AW > 16) begin : g_bad_aw
         $error("rawlock_unit: REG_AW must lie in 1..16");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cw
         $error("rawlock_unit: CNT_W must lie in 2..16");
      end
   endgenerate

   // Flattened producer descriptors, indexed by ahead_e.
   logic [NSTG*REG_AW-1:0] dst_flat;
   logic [NSTG-1:0]        dst_vld;
   logic [NSTG-1:0]        dst_wen;

   assign dst_flat[int'(AHEAD_EX)*REG_AW  +: REG_AW] = ex_rd;
   assign dst_flat[int'(AHEAD_MEM)*REG_AW +: REG_AW] = mem_rd;
   assign dst_flat[int'(AHEAD_WB)*REG_AW  +: REG_AW] = wb_rd;
   assign dst_vld = {wb_vld, mem_vld, ex_vld};
   assign dst_wen = {wb_wen, mem_wen, ex_wen};

   logic [REG_AW-1:0] src_num [NSRC];
   logic [NSRC-1:0]   src_use;
   logic [NSRC-1:0]   src_hit;

   assign src_num[0] = id_rs_a;
   assign src_num[1] = id_rs_b;
   assign src_use    = {id_rs_b_use, id_rs_a_use};

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         rawlock_src #(
            .AW        (REG_AW),
            .NSTG      (NSTG),
            .LIVE_MASK (LIVE_MASK),
            .ZERO_SKIP (ZERO_REG_FIXED)
         ) u_src (
            .src      (src_num[s]),
            .src_use  (src_use[s]),
            .dst_flat (dst_flat),
            .dst_vld  (dst_vld),
            .dst_wen  (dst_wen),
            .hit      (src_hit[s])
         );
      end
   endgenerate

   logic hold_req;
   assign hold_req    = |src_hit;
   assign stall_fetch = hold_req;
   assign bubble_ex   = hold_req;

   rawlock_holdcnt #(
      .CW (CNT_W)
   ) u_holdcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .stall (hold_req),
      .cnt   (hold_count)
   );

endmodule

// File: rtl/rawlock_unit_chk.sv
`timescale 1ns/1ps
module rawlock_unit_chk #(
   parameter int unsigned AW = 5,
   parameter int unsigned CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] id_rs_a,
   input logic          id_rs_a_use,
   input logic [AW-1:0] id_rs_b,
   input logic          id_rs_b_use,
   input logic          ex_vld,
   input logic          ex_wen,
   input logic [AW-1:0] ex_rd,
   input logic          mem_vld,
   input logic          mem_wen,
   input logic [AW-1:0] mem_rd,
   input logic          stall_fetch,
   input logic [CW-1:0] hold_count
);

   localparam logic [CW-1:0] CNT_TOP = '1;

   logic ex_dep, mem_dep;
   assign ex_dep  = ex_vld && ex_wen && (ex_rd != '0) &&
                    ((id_rs_a_use && id_rs_a == ex_rd) || (id_rs_b_use && id_rs_b == ex_rd));
   assign mem_dep = mem_vld && mem_wen && (mem_rd != '0) &&
                    ((id_rs_a_use && id_rs_a == mem_rd) || (id_rs_b_use && id_rs_b == mem_rd));

   // R1, R10
   assert_ex_dep_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ex_dep |-> stall_fetch);

   // R2
   assert_mem_dep_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dep |-> stall_fetch);

   // R3, R4, R5, R6: nothing but an execute or memory dependency may stall
   assert_no_false_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_dep || mem_dep) |-> !stall_fetch);

   // R8
   assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_fetch |=> hold_count == '0);

   assert_hold_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_fetch && hold_count != CNT_TOP) |=> hold_count == CW'($past(hold_count) + 1'b1));

   assert_hold_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_fetch && hold_count == CNT_TOP) |=> hold_count == CNT_TOP);

endmodule

bind rawlock_unit rawlock_unit_chk #(
   .AW (REG_AW),
   .CW (CNT_W)
) u_rawlock_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .id_rs_a     (id_rs_a),
   .id_rs_a_use (id_rs_a_use),
   .id_rs_b     (id_rs_b),
   .id_rs_b_use (id_rs_b_use),
   .ex_vld      (ex_vld),
   .ex_wen      (ex_wen),
   .ex_rd       (ex_rd),
   .mem_vld     (mem_vld),
   .mem_wen     (mem_wen),
   .mem_rd      (mem_rd),
   .stall_fetch (stall_fetch),
   .hold_count  (hold_count)
);

// File: tb/rawlock_unit_bench.sv
`timescale 1ns/1ps
module rawlock_unit_bench;

   localparam int AW   = 5;
   localparam int CW   = 3;
   localparam int HMAX = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0] rs_a = '0, rs_b = '0;
   logic          a_use = 1'b0, b_use = 1'b0;
   logic          ex_v = 1'b0, ex_w = 1'b0, mem_v = 1'b0, mem_w = 1'b0, wb_v = 1'b0, wb_w = 1'b0;
   logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
   logic          stall, bubble;
   logic [CW-1:0] hold;

   rawlock_unit u_rawlock_unit (
      .clk (clk), .rst_n (rst_n),
      .id_rs_a (rs_a), .id_rs_a_use (a_use), .id_rs_b (rs_b), .id_rs_b_use (b_use),
      .ex_vld (ex_v), .ex_wen (ex_w), .ex_rd (ex_rd),
      .mem_vld (mem_v), .mem_wen (mem_w), .mem_rd (mem_rd),
      .wb_vld (wb_v), .wb_wen (wb_w), .wb_rd (wb_rd),
      .stall_fetch (stall), .bubble_ex (bubble), .hold_count (hold)
   );

   int n_cmp = 0, n_bad = 0, stall_seen = 0, model_hold = 0;
   bit finished = 1'b0;
   bit    q_stall[$];
   int    q_hold[$];
   string q_tag[$];

   // descriptor layout: {valid, write enable, destination[4:0]}
   function automatic bit dep(logic [6:0] d, logic [4:0] a, bit au, logic [4:0] b, bit bu);
      return d[6] && d[5] && (d[4:0] != 5'd0) &&
             ((au && a == d[4:0]) || (bu && b == d[4:0]));
   endfunction

   task automatic apply(input logic [4:0] a, input bit au, input logic [4:0] b, input bit bu,
                        input logic [6:0] ex, input logic [6:0] mem, input logic [6:0] wb,
                        input string tag, output bit s);
      @(negedge clk);
      rs_a = a; a_use = au; rs_b = b; b_use = bu;
      {ex_v, ex_w, ex_rd}    = ex;
      {mem_v, mem_w, mem_rd} = mem;
      {wb_v, wb_w, wb_rd}    = wb;
      s = dep(ex, a, au, b, bu) || dep(mem, a, au, b, bu);
      q_stall.push_back(s);
      q_hold.push_back(model_hold);
      q_tag.push_back(tag);
      model_hold = s ? ((model_hold == HMAX) ? HMAX : model_hold + 1) : 0;
   endtask

   // monitor: pops expected items and compares them with the outputs
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q_stall.size() > 0) begin
            bit es; int eh; string t;
            es = q_stall.pop_front();
            eh = q_hold.pop_front();
            t  = q_tag.pop_front();
            n_cmp++;
            if (stall) stall_seen++;
            if (stall !== es || bubble !== es || hold !== eh[CW-1:0]) begin
               n_bad++;
               $display("FAIL %s (R7 bubble, R8 hold): stall=%0b bubble=%0b hold=%0d, expected stall=%0b bubble=%0b hold=%0d",
                        t, stall, bubble, hold, es, es, eh);
            end
         end
      end
   end

   // pipeline program storage for the R9 runs
   bit       p_wen[4];
   logic [4:0] p_rd[4], p_a[4], p_b[4];
   bit       p_au[4], p_bu[4];
   int       p_n;

   task automatic run_prog(input string tag, input int cycles);
      logic [6:0] ex, mem, wb;
      logic [4:0] da, db;
      bit dau, dbu, s;
      int pc;
      ex = '0; mem = '0; wb = '0; pc = 0;
      for (int c = 0; c < cycles; c++) begin
         if (pc < p_n) begin
            da = p_a[pc]; dau = p_au[pc]; db = p_b[pc]; dbu = p_bu[pc];
         end else begin
            da = '0; dau = 1'b0; db = '0; dbu = 1'b0;
         end
         apply(da, dau, db, dbu, ex, mem, wb, tag, s);
         wb  = mem;
         mem = ex;
         if (s) begin
            ex = '0;
         end else if (pc < p_n) begin
            ex = {1'b1, p_wen[pc], p_rd[pc]};
            pc++;
         end else begin
            ex = '0;
         end
      end
   endtask

   task automatic drain();
      @(negedge clk);
      #2;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      bit s;
      repeat (3) @(negedge clk);
      #1;
      n_cmp++;
      if (hold !== '0 || stall !== 1'b0) begin
         n_bad++;
         $display("FAIL R8 reset: hold=%0d stall=%0b, expected hold=0 stall=0", hold, stall);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1: first source against execute
      apply(5'd5, 1, 5'd0, 0, {1'b1,1'b1,5'd5}, 7'd0, 7'd0, "R1 ex match rs_a", s);
      // R10: second source against execute
      apply(5'd1, 1, 5'd9, 1, {1'b1,1'b1,5'd9}, 7'd0, 7'd0, "R10 ex match rs_b", s);
      // R2: memory stage match on each source
      apply(5'd12, 1, 5'd3, 1, 7'd0, {1'b1,1'b1,5'd12}, 7'd0, "R2 mem match rs_a", s);
      apply(5'd4, 1, 5'd30, 1, {1'b1,1'b1,5'd6}, {1'b1,1'b1,5'd30}, 7'd0, "R2 R10 mem match rs_b", s);
      // R3: write-back match only
      apply(5'd8, 1, 5'd8, 1, {1'b1,1'b1,5'd2}, {1'b1,1'b1,5'd3}, {1'b1,1'b1,5'd8}, "R3 wb match no stall", s);
      // R4: invalid or non-writing producers
      apply(5'd7, 1, 5'd7, 1, {1'b0,1'b1,5'd7}, {1'b1,1'b0,5'd7}, 7'd0, "R4 invalid or no write", s);
      apply(5'd7, 1, 5'd0, 0, {1'b1,1'b0,5'd7}, {1'b0,1'b1,5'd7}, 7'd0, "R4 swapped flags", s);
      // R5: register zero
      apply(5'd0, 1, 5'd0, 1, {1'b1,1'b1,5'd0}, {1'b1,1'b1,5'd0}, 7'd0, "R5 zero destination", s);
      // R6: unused sources matching
      apply(5'd11, 0, 5'd13, 0, {1'b1,1'b1,5'd11}, {1'b1,1'b1,5'd13}, 7'd0, "R6 unused sources", s);
      apply(5'd11, 0, 5'd14, 1, {1'b1,1'b1,5'd11}, 7'd0, 7'd0, "R6 unused a, b free", s);

      // R8: long stall saturates, then clears
      for (int i = 0; i < 11; i++)
         apply(5'd21, 1, 5'd0, 0, {1'b1,1'b1,5'd21}, 7'd0, 7'd0, "R8 saturating hold", s);
      apply(5'd21, 1, 5'd0, 0, 7'd0, 7'd0, {1'b1,1'b1,5'd21}, "R8 hold release", s);
      apply(5'd21, 1, 5'd0, 0, 7'd0, 7'd0, 7'd0, "R8 hold zero", s);
      drain();

      // R9: dependency on the instruction directly ahead
      p_n = 4;
      p_wen = '{1, 0, 0, 0};
      p_rd  = '{5'd5, 5'd0, 5'd0, 5'd0};
      p_a   = '{5'd0, 5'd5, 5'd0, 5'd0};
      p_au  = '{0, 1, 0, 0};
      p_b   = '{5'd0, 5'd0, 5'd0, 5'd0};
      p_bu  = '{0, 0, 0, 0};
      stall_seen = 0;
      run_prog("R9 adjacent dependency", 9);
      drain();
      n_cmp++;
      if (stall_seen != 2) begin
         n_bad++;
         $display("FAIL R9 adjacent dependency stall cycles: actual=%0d expected=2", stall_seen);
      end

      // R9: dependency two instructions ahead, through the second source
      p_n = 3;
      p_wen = '{1, 1, 0, 0};
      p_rd  = '{5'd7, 5'd9, 5'd0, 5'd0};
      p_a   = '{5'd0, 5'd1, 5'd3, 5'd0};
      p_au  = '{0, 1, 1, 0};
      p_b   = '{5'd0, 5'd2, 5'd7, 5'd0};
      p_bu  = '{0, 1, 1, 0};
      stall_seen = 0;
      run_prog("R9 R10 distance-two dependency", 9);
      drain();
      n_cmp++;
      if (stall_seen != 1) begin
         n_bad++;
         $display("FAIL R9 distance-two dependency stall cycles: actual=%0d expected=1", stall_seen);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule